// File: doc/BRIEF.md
# SPI Target Transfer Engine with Bounded Buffers

This block is the serial side of an SPI target (slave) port. An external master selects it with an active-low chip select and clocks bytes in on MOSI while the block shifts bytes out on MISO. Outgoing bytes are fetched from a synchronous-read transmit buffer port. Incoming bytes are written to a receive buffer port. Each direction has its own 8-bit length limit. When the master runs past a limit, the block sends a filler character or drops the byte, and it records the event in a sticky flag.

SCK, MOSI and chip select are oversampled in the system clock domain, so the SCK half period must span several system clocks. A transaction runs from chip-select fall to chip-select rise. Ownership of the buffers is a single grant input, which is sampled when the transaction starts. At the end of a granted transaction the block pulses a done output. It also latches how many buffer bytes were sent and how many were stored.

Top module: `spi_tgt_xfer`

## Requirements
- R1: The clock mode is set by `cfg_idle_hi_i` (SCK idle level; 1 means idle high) and `cfg_late_sample_i` (0 samples on the leading edge, 1 samples on the trailing edge). MOSI is sampled on the selected edge in all four combinations.
- R2: In leading-edge sampling modes, the first MISO bit is valid before the first SCK edge, and later bits change on trailing edges. In trailing-edge sampling modes, every bit, the first one included, is driven on a leading edge.
- R3: `cfg_lsb_first_i`=1 shifts bit 0 first on both MISO and MOSI. With 0, bit 7 goes first.
- R4: In a granted transaction, outgoing byte k with k < `tx_max_i` is read from transmit buffer address k.
- R5: In a granted transaction, every outgoing byte with index k >= `tx_max_i` is `overread_char_i`. When such a byte completes, the over-read flag is set.
- R6: In a granted transaction, each complete incoming byte k with k < `rx_max_i` is written once to receive buffer address k, in order.
- R7: In a granted transaction, complete incoming bytes with k >= `rx_max_i` are not written, and they set the overflow flag.
- R8: When chip select rises after a granted transaction of n complete bytes, `xfer_done_o` pulses for one cycle. At the same time `tx_amount_o` becomes min(n, `tx_max_i`) and `rx_amount_o` becomes min(n, `rx_max_i`). Trailing bits that do not form a whole byte are neither stored nor counted.
- R9: If `grant_i` is low when chip select falls, every MISO byte is `unowned_char_i`. In that case there are no buffer writes, no done pulse, and the amounts and flags stay unchanged.
- R10: `spi_miso_oe_o` is low while chip select is high.
- R11: The flags are sticky. Writing 1 to `flag_clr_i[0]` clears over-read, and writing 1 to `flag_clr_i[1]` clears overflow. If a set and a clear happen in the same cycle, the set wins.
- R12: After reset, the output enable, done, strobes, amounts and flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck_i | input | 1 | Serial clock from master |
| spi_mosi_i | input | 1 | Serial data from master |
| spi_csn_n_i | input | 1 | Chip select, active low |
| spi_miso_o | output | 1 | Serial data to master |
| spi_miso_oe_o | output | 1 | MISO output enable |
| cfg_idle_hi_i | input | 1 | SCK idle level |
| cfg_late_sample_i | input | 1 | Sample on trailing edge |
| cfg_lsb_first_i | input | 1 | Bit order select |
| tx_max_i | input | 8 | Transmit buffer length |
| rx_max_i | input | 8 | Receive buffer length |
| overread_char_i | input | 8 | Filler sent past transmit length |
| unowned_char_i | input | 8 | Filler sent when not granted |
| grant_i | input | 1 | Buffer ownership grant |
| txb_rd_en_o | output | 1 | Transmit buffer read strobe |
| txb_addr_o | output | 8 | Transmit buffer address |
| txb_rd_data_i | input | 8 | Read data, one cycle after strobe |
| rxb_wr_en_o | output | 1 | Receive buffer write strobe |
| rxb_addr_o | output | 8 | Receive buffer address |
| rxb_wr_data_o | output | 8 | Receive buffer write data |
| xfer_done_o | output | 1 | End-of-transaction pulse |
| tx_amount_o | output | 8 | Bytes sent from buffer |
| rx_amount_o | output | 8 | Bytes stored to buffer |
| overread_flag_o | output | 1 | Sticky over-read flag |
| overflow_flag_o | output | 1 | Sticky overflow flag |
| flag_clr_i | input | 2 | Write-one-to-clear for flags |

## Verification
The following are checked on every cycle: the flags stay set unless cleared, the done strobe lasts one cycle and arrives with amounts no larger than the limits, writes stay below the receive limit, and the output enable drops once chip select is high. Only the scenarios can show the mode-dependent edge timing and bit order, the per-index choice between buffer data and filler, that stored bytes match the shifted data, and that a transaction without a grant leaves no trace. Partial trailing bytes are checked the same way.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 8;
  localparam int IDX_W  = CNT_W + 1;

  typedef struct packed {
    logic idle_hi;
    logic late_sample;
    logic lsb_first;
  } spi_cfg_t;

  // bit that leaves the shifter next
  function automatic logic lead_bit(input logic [BYTE_W-1:0] b, input logic lsb);
    return lsb ? b[0] : b[BYTE_W-1];
  endfunction

  // shifter after one bit has left
  function automatic logic [BYTE_W-1:0] advance(input logic [BYTE_W-1:0] b, input logic lsb);
    return lsb ? (b >> 1) : (b << 1);
  endfunction

  // receive shifter after one bit enters
  function automatic logic [BYTE_W-1:0] absorb(input logic [BYTE_W-1:0] sh,
                                              input logic bit_in, input logic lsb);
    return lsb ? {bit_in, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], bit_in};
  endfunction

  // amount reported for n complete bytes against a limit
  function automatic logic [CNT_W-1:0] clamp_count(input logic [IDX_W-1:0] n,
                                                  input logic [CNT_W-1:0] lim);
    return (n >= {1'b0, lim}) ? lim : n[CNT_W-1:0];
  endfunction

  // saturating increment of a byte index
  function automatic logic [IDX_W-1:0] sat_inc(input logic [IDX_W-1:0] n);
    return (&n) ? n : n + 1'b1;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_raw,
  input  logic csn_raw,
  input  logic mosi_raw,
  output logic sck_rise,
  output logic sck_fall,
  output logic csn_fall,
  output logic csn_rise,
  output logic csn_s,
  output logic mosi_s
);
  localparam int LAST = STAGES - 1;
  localparam logic [2:0] RST_VAL = 3'b010; // {sck, csn, mosi}

  logic [2:0] stage_q [STAGES];
  logic [1:0] prev_q; // {sck, csn}

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
      prev_q <= RST_VAL[2:1];
    end else begin
      stage_q[0] <= {sck_raw, csn_raw, mosi_raw};
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      prev_q <= stage_q[LAST][2:1];
    end
  end

  logic sck_s;
  assign sck_s    = stage_q[LAST][2];
  assign csn_s    = stage_q[LAST][1];
  assign mosi_s   = stage_q[LAST][0];
  assign sck_rise = sck_s & ~prev_q[1];
  assign sck_fall = ~sck_s & prev_q[1];
  assign csn_fall = ~csn_s & prev_q[0];
  assign csn_rise = csn_s & ~prev_q[0];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  spi_cfg_t          cfg,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              csn_fall,
  input  logic              csn_rise,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] nb_data,
  input  logic              nb_ready,
  output logic              miso_bit,
  output logic              active,
  output logic              consume,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

  logic              active_q, first_pend_q, miso_q, done_q;
  logic [BC_W-1:0]   tx_cnt_q, rx_cnt_q;
  logic [BYTE_W-1:0] tx_cur_q, rx_sh_q, rx_byte_q;

  logic leading, trailing, live, sample_ev, drive_ev, first_kick;
  logic [BYTE_W-1:0] tx_src, rx_next;

  assign leading    = cfg.idle_hi ? sck_fall : sck_rise;
  assign trailing   = cfg.idle_hi ? sck_rise : sck_fall;
  assign live       = active_q & ~csn_rise;
  // leading-edge sampling needs the first bit on the wire before any edge
  assign first_kick = first_pend_q & ~cfg.late_sample & nb_ready;
  assign sample_ev  = live & (cfg.late_sample ? trailing : leading);
  assign drive_ev   = live & ((cfg.late_sample ? leading : trailing) | first_kick);
  assign consume    = drive_ev & (tx_cnt_q == '0);
  assign tx_src     = consume ? nb_data : tx_cur_q;
  assign rx_next    = absorb(rx_sh_q, mosi_s, cfg.lsb_first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q     <= 1'b0;
      first_pend_q <= 1'b0;
      miso_q       <= 1'b0;
      done_q       <= 1'b0;
      tx_cnt_q     <= '0;
      rx_cnt_q     <= '0;
      tx_cur_q     <= '0;
      rx_sh_q      <= '0;
      rx_byte_q    <= '0;
    end else begin
      done_q <= sample_ev & (rx_cnt_q == LAST_BIT);
      if (csn_fall) begin
        active_q     <= 1'b1;
        first_pend_q <= 1'b1;
        miso_q       <= 1'b0;
        tx_cnt_q     <= '0;
        rx_cnt_q     <= '0;
        rx_sh_q      <= '0;
      end else begin
        if (csn_rise) active_q <= 1'b0;
        if (drive_ev) begin
          first_pend_q <= 1'b0;
          miso_q       <= lead_bit(tx_src, cfg.lsb_first);
          tx_cur_q     <= advance(tx_src, cfg.lsb_first);
          tx_cnt_q     <= tx_cnt_q + 1'b1;
        end
        if (sample_ev) begin
          rx_sh_q   <= rx_next;
          rx_cnt_q  <= rx_cnt_q + 1'b1;
          rx_byte_q <= rx_next;
        end
      end
    end
  end

  assign miso_bit  = miso_q;
  assign active    = active_q;
  assign byte_done = done_q;
  assign rx_byte   = rx_byte_q;

  AST_DONE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(active_q)); // R6
endmodule

// File: rtl/spi_buf_ctrl.sv
module spi_buf_ctrl
  import spi_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_fall,
  input  logic              csn_rise,
  input  logic              grant_i,
  input  logic              consume,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [CNT_W-1:0]  tx_max,
  input  logic [CNT_W-1:0]  rx_max,
  input  logic [BYTE_W-1:0] overread_char,
  input  logic [BYTE_W-1:0] unowned_char,
  input  logic [1:0]        flag_clr,
  output logic              txb_rd_en,
  output logic [CNT_W-1:0]  txb_addr,
  input  logic [BYTE_W-1:0] txb_rd_data,
  output logic              rxb_wr_en,
  output logic [CNT_W-1:0]  rxb_addr,
  output logic [BYTE_W-1:0] rxb_wr_data,
  output logic [BYTE_W-1:0] nb_data,
  output logic              nb_ready,
  output logic              done,
  output logic [CNT_W-1:0]  tx_amount,
  output logic [CNT_W-1:0]  rx_amount,
  output logic              overread_flag,
  output logic              overflow_flag
);
  logic              grant_q, in_xfer_q, mem_pend_q, nb_ready_q, done_q;
  logic              ovr_q, ovf_q;
  logic [IDX_W-1:0]  fetch_idx_q, full_cnt_q;
  logic [BYTE_W-1:0] nb_data_q;
  logic [CNT_W-1:0]  tx_amt_q, rx_amt_q;

  logic             fetch_go, fetch_grant, from_mem;
  logic [IDX_W-1:0] fetch_tgt;
  logic             set_ovr, set_ovf;

  assign fetch_go    = csn_fall | consume;
  assign fetch_tgt   = csn_fall ? '0 : sat_inc(fetch_idx_q);
  assign fetch_grant = csn_fall ? grant_i : grant_q;
  assign from_mem    = fetch_grant & (fetch_tgt < {1'b0, tx_max});
  assign txb_rd_en   = fetch_go & from_mem;
  assign txb_addr    = fetch_tgt[CNT_W-1:0];

  assign rxb_wr_en   = byte_done & grant_q & (full_cnt_q < {1'b0, rx_max});
  assign rxb_addr    = full_cnt_q[CNT_W-1:0];
  assign rxb_wr_data = rx_byte;
  assign set_ovr     = byte_done & grant_q & (full_cnt_q >= {1'b0, tx_max});
  assign set_ovf     = byte_done & grant_q & (full_cnt_q >= {1'b0, rx_max});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q     <= 1'b0;
      in_xfer_q   <= 1'b0;
      mem_pend_q  <= 1'b0;
      nb_ready_q  <= 1'b0;
      nb_data_q   <= '0;
      fetch_idx_q <= '0;
      full_cnt_q  <= '0;
      done_q      <= 1'b0;
      tx_amt_q    <= '0;
      rx_amt_q    <= '0;
      ovr_q       <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      // next outgoing byte: buffer data one cycle after the strobe, or a filler now
      mem_pend_q <= txb_rd_en;
      nb_ready_q <= 1'b0;
      if (fetch_go) fetch_idx_q <= fetch_tgt;
      if (mem_pend_q) begin
        nb_data_q  <= txb_rd_data;
        nb_ready_q <= 1'b1;
      end else if (fetch_go && !from_mem) begin
        nb_data_q  <= fetch_grant ? overread_char : unowned_char;
        nb_ready_q <= 1'b1;
      end

      if (csn_fall) begin
        grant_q    <= grant_i;
        in_xfer_q  <= 1'b1;
        full_cnt_q <= '0;
      end else if (byte_done) begin
        full_cnt_q <= sat_inc(full_cnt_q);
      end

      done_q <= 1'b0;
      if (csn_rise && in_xfer_q) begin
        in_xfer_q <= 1'b0;
        if (grant_q) begin
          done_q   <= 1'b1;
          tx_amt_q <= clamp_count(full_cnt_q, tx_max);
          rx_amt_q <= clamp_count(full_cnt_q, rx_max);
        end
      end

      ovr_q <= set_ovr | (ovr_q & ~flag_clr[0]);
      ovf_q <= set_ovf | (ovf_q & ~flag_clr[1]);
    end
  end

  assign nb_data       = nb_data_q;
  assign nb_ready      = nb_ready_q;
  assign done          = done_q;
  assign tx_amount     = tx_amt_q;
  assign rx_amount     = rx_amt_q;
  assign overread_flag = ovr_q;
  assign overflow_flag = ovf_q;

  AST_OVERREAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !flag_clr[0] |=> ovr_q); // R11
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !flag_clr[1] |=> ovf_q); // R11
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_wr_en |-> !ovf_q || $past(ovf_q) || !set_ovf); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_TX_AMOUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> tx_amt_q <= tx_max); // R8
  AST_RX_AMOUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> rx_amt_q <= rx_max); // R8
endmodule

// File: rtl/spi_tgt_xfer.sv
module spi_tgt_xfer
  import spi_xfer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck_i,
  input  logic              spi_mosi_i,
  input  logic              spi_csn_n_i,
  output logic              spi_miso_o,
  output logic              spi_miso_oe_o,
  input  logic              cfg_idle_hi_i,
  input  logic              cfg_late_sample_i,
  input  logic              cfg_lsb_first_i,
  input  logic [CNT_W-1:0]  tx_max_i,
  input  logic [CNT_W-1:0]  rx_max_i,
  input  logic [BYTE_W-1:0] overread_char_i,
  input  logic [BYTE_W-1:0] unowned_char_i,
  input  logic              grant_i,
  output logic              txb_rd_en_o,
  output logic [CNT_W-1:0]  txb_addr_o,
  input  logic [BYTE_W-1:0] txb_rd_data_i,
  output logic              rxb_wr_en_o,
  output logic [CNT_W-1:0]  rxb_addr_o,
  output logic [BYTE_W-1:0] rxb_wr_data_o,
  output logic              xfer_done_o,
  output logic [CNT_W-1:0]  tx_amount_o,
  output logic [CNT_W-1:0]  rx_amount_o,
  output logic              overread_flag_o,
  output logic              overflow_flag_o,
  input  logic [1:0]        flag_clr_i
);
  spi_cfg_t cfg;
  assign cfg = '{idle_hi: cfg_idle_hi_i, late_sample: cfg_late_sample_i,
                 lsb_first: cfg_lsb_first_i};

  // internal events, named for the checks below
  logic sck_rise, sck_fall, csn_fall, csn_rise, csn_s, mosi_s;
  logic active, consume, byte_done, nb_ready;
  logic [BYTE_W-1:0] rx_byte, nb_data;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .sck_raw(spi_sck_i), .csn_raw(spi_csn_n_i), .mosi_raw(spi_mosi_i),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .csn_fall(csn_fall), .csn_rise(csn_rise),
    .csn_s(csn_s), .mosi_s(mosi_s)
  );

  spi_bit_engine engine_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .csn_fall(csn_fall), .csn_rise(csn_rise), .mosi_s(mosi_s),
    .nb_data(nb_data), .nb_ready(nb_ready),
    .miso_bit(spi_miso_o), .active(active), .consume(consume),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  spi_buf_ctrl buf_i (
    .clk(clk), .rst_n(rst_n),
    .csn_fall(csn_fall), .csn_rise(csn_rise), .grant_i(grant_i),
    .consume(consume), .byte_done(byte_done), .rx_byte(rx_byte),
    .tx_max(tx_max_i), .rx_max(rx_max_i),
    .overread_char(overread_char_i), .unowned_char(unowned_char_i),
    .flag_clr(flag_clr_i),
    .txb_rd_en(txb_rd_en_o), .txb_addr(txb_addr_o), .txb_rd_data(txb_rd_data_i),
    .rxb_wr_en(rxb_wr_en_o), .rxb_addr(rxb_addr_o), .rxb_wr_data(rxb_wr_data_o),
    .nb_data(nb_data), .nb_ready(nb_ready),
    .done(xfer_done_o), .tx_amount(tx_amount_o), .rx_amount(rx_amount_o),
    .overread_flag(overread_flag_o), .overflow_flag(overflow_flag_o)
  );

  assign spi_miso_oe_o = active;

  AST_OE_DROPS_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn_s) |=> !spi_miso_oe_o); // R10
  AST_DONE_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |-> csn_s); // R8
  AST_WR_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_wr_en_o |-> rxb_addr_o < rx_max_i); // R7
  AST_RD_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    txb_rd_en_o |-> txb_addr_o < tx_max_i); // R5
endmodule

// File: tb/spi_tgt_xfer_tb_top.sv
module spi_tgt_xfer_tb_top;
  localparam int H = 8; // SCK half period in system clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic sck = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic miso, miso_oe;
  logic idle_hi = 1'b0, late = 1'b0, lsb = 1'b0;
  logic [7:0] txl = 8'd4, rxl = 8'd4, orc = 8'hE7, defc = 8'h3C;
  logic gnt = 1'b1;
  logic rd_en, wr_en, done;
  logic [7:0] rd_addr, wr_addr, wr_data, tx_amt, rx_amt;
  logic [7:0] rd_data = 8'h00;
  logic ovr, ovf;
  logic [1:0] clr = 2'b00;

  spi_tgt_xfer dut_i (
    .clk(clk), .rst_n(rst_n),
    .spi_sck_i(sck), .spi_mosi_i(mosi), .spi_csn_n_i(csn),
    .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
    .cfg_idle_hi_i(idle_hi), .cfg_late_sample_i(late), .cfg_lsb_first_i(lsb),
    .tx_max_i(txl), .rx_max_i(rxl),
    .overread_char_i(orc), .unowned_char_i(defc), .grant_i(gnt),
    .txb_rd_en_o(rd_en), .txb_addr_o(rd_addr), .txb_rd_data_i(rd_data),
    .rxb_wr_en_o(wr_en), .rxb_addr_o(wr_addr), .rxb_wr_data_o(wr_data),
    .xfer_done_o(done), .tx_amount_o(tx_amt), .rx_amount_o(rx_amt),
    .overread_flag_o(ovr), .overflow_flag_o(ovf), .flag_clr_i(clr)
  );

  // transmit buffer: synchronous read
  logic [7:0] txmem [256];
  initial for (int i = 0; i < 256; i++) txmem[i] = 8'(i * 37 + 5);
  always @(posedge clk) if (rd_en) rd_data <= txmem[rd_addr];

  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard of expected receive-buffer writes {addr, data}
  logic [15:0] wr_q [$];
  int done_seen = 0;
  always @(negedge clk) begin
    if (rst_n && done) done_seen++;
    if (rst_n && wr_en) begin
      if (wr_q.size() == 0) chk("R7 unexpected write", {wr_addr, wr_data}, 16'hxxxx);
      else chk("R6 write", {wr_addr, wr_data}, wr_q.pop_front());
    end
  end

  bit m_ovr = 0, m_ovf = 0;
  logic [7:0] m_tx = 0, m_rx = 0;

  function automatic logic [7:0] mo_byte(int k, int mode);
    return 8'hA5 ^ 8'(k * 19) ^ 8'(mode * 7);
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // master transaction; checks MISO bytes and end-of-transaction state
  task automatic xfer(int mode, bit lsb_f, bit g, int nbytes, int extra);
    int total = nbytes * 8 + extra;
    logic [7:0] rb = 0;
    int done0 = done_seen;
    idle_hi = mode[1]; late = mode[0]; lsb = lsb_f; gnt = g;
    sck = mode[1];
    for (int k = 0; k < nbytes; k++)
      if (g && k < int'(rxl)) wr_q.push_back({8'(k), mo_byte(k, mode)});
    wait_clk(4);
    csn = 1'b0;
    wait_clk(10);
    for (int b = 0; b < total; b++) begin
      int k = b / 8;
      int j = b % 8;
      logic [7:0] mb = mo_byte(k, mode);
      logic mbit = lsb_f ? mb[j] : mb[7 - j];
      logic sb;
      if (!mode[0]) begin
        mosi = mbit;
        wait_clk(H); sb = miso; sck = ~sck;
        wait_clk(H); sck = ~sck;
      end else begin
        sck = ~sck; mosi = mbit;
        wait_clk(H); sb = miso; sck = ~sck;
        wait_clk(H);
      end
      rb = lsb_f ? {sb, rb[7:1]} : {rb[6:0], sb};
      if (j == 7) begin
        logic [7:0] exp = !g ? defc : (k < int'(txl) ? txmem[k] : orc);
        chk((!g ? "R9 miso" : (k < int'(txl) ? "R4 R1 R2 R3 miso" : "R5 miso")), rb, exp);
      end
    end
    wait_clk(H);
    csn = 1'b1;
    wait_clk(12);
    chk("R6 R7 pending writes", wr_q.size(), 0);
    chk("R10 oe", miso_oe, 1'b0);
    if (g) begin
      chk("R8 done", done_seen - done0, 1);
      m_tx = (nbytes < int'(txl)) ? 8'(nbytes) : txl;
      m_rx = (nbytes < int'(rxl)) ? 8'(nbytes) : rxl;
      if (nbytes > int'(txl)) m_ovr = 1;
      if (nbytes > int'(rxl)) m_ovf = 1;
    end else begin
      chk("R9 no done", done_seen - done0, 0);
    end
    chk("R8 tx amount", tx_amt, m_tx);
    chk("R8 rx amount", rx_amt, m_rx);
    chk("R5 over-read flag", ovr, m_ovr);
    chk("R7 overflow flag", ovf, m_ovf);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R12 reset state
    chk("R12 oe", miso_oe, 0);
    chk("R12 done", done, 0);
    chk("R12 strobes", {rd_en, wr_en}, 0);
    chk("R12 amounts", {tx_amt, rx_amt}, 0);
    chk("R12 flags", {ovr, ovf}, 0);
    chk("R10 oe idle", miso_oe, 0);

    txl = 8'd4; rxl = 8'd4;
    xfer(0, 0, 1, 3, 0);          // mode 0, MSB first, within limits
    txl = 8'd2; rxl = 8'd5;
    xfer(1, 1, 1, 4, 0);          // mode 1, LSB first, over-read
    txl = 8'd6; rxl = 8'd2;
    xfer(2, 0, 1, 4, 3);          // mode 2, overflow, partial byte

    // R11 write-one-to-clear, one flag at a time
    clr = 2'b01; wait_clk(1); clr = 2'b00; wait_clk(2);
    m_ovr = 0;
    chk("R11 over-read cleared", ovr, 0);
    chk("R11 overflow kept", ovf, 1);
    clr = 2'b10; wait_clk(1); clr = 2'b00; wait_clk(2);
    m_ovf = 0;
    chk("R11 overflow cleared", ovf, 0);

    txl = 8'd8; rxl = 8'd8;
    xfer(3, 1, 0, 2, 0);          // mode 3, not granted
    txl = 8'd0; rxl = 8'd0;
    xfer(0, 1, 1, 2, 5);          // zero limits
    txl = 8'd3; rxl = 8'd3;
    xfer(3, 0, 1, 3, 0);          // mode 3 granted, exact limits

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule